// File: doc/BRIEF.md
# Byte-Flagged Mailbox Interrupt Controller

This block carries 32-bit messages between a host side and a local add-on side in two banks of four mailboxes. The host pushes words into the incoming bank through a simple write port. It pulls words out of the outgoing bank through a combinational read port. The add-on side reaches both banks through one register port. That port also exposes a packed status word and an interrupt control/status word.

Every byte of every mailbox has its own flag. An incoming byte is marked full when the host writes it and returns to not-full when the add-on reads it. An outgoing byte is marked not-empty when the add-on writes it and returns to empty when the host reads it. Byte enables on each access select which flags change.

Two sticky interrupt bits, one per direction, drive an active-low interrupt line to the add-on side. Software clears each bit by writing one to it. A single flag-reset control bit returns every byte flag to its idle value at once.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, all incoming full flags read 0, all outgoing empty flags read 1, the control word reads 0 and `irqN` is 1.
- R2: Register addresses are: 0–3 incoming mailboxes 0–3 (read); 4–7 outgoing mailboxes 0–3 (read/write); 8 status; 9 control. Status bits 15:0 are incoming full flags and bits 31:16 are outgoing empty flags. The flag for mailbox m, byte k sits at bit m*4+k of its half. Reads return the whole word whatever the byte enables.
- R3: A host write stores the enabled bytes of `hostWrData` into incoming mailbox `hostWrBox` and sets their full flags one cycle later. If control bit 0 (incoming enable) is 1, it also sets control bit 16 (incoming interrupt).
- R4: An add-on read of an incoming mailbox returns its contents in the same cycle. It clears only the full flags of the bytes enabled by `regBe`, and those flags read 0 from the next cycle.
- R5: An add-on write to an outgoing mailbox stores the enabled bytes and clears their empty flags. A host read returns the word of `hostRdBox` in the same cycle and sets the empty flags enabled by `hostRdBe`. If control bit 1 (outgoing enable) is 1, the host read also sets control bit 17 (outgoing interrupt).
- R6: Interrupt bits 16 and 17 are sticky. Writing 1 to one of them clears it. Writing 0 leaves it unchanged. Writing the enable bits never clears them.
- R7: `irqN` is 0 while bit 16 or bit 17 is set, and returns to 1 only once both are clear.
- R8: A write of 1 to bit 16 is ignored while any incoming full flag is 1.
- R9: Writing 1 to control bit 24 (flag reset) clears all incoming full flags and sets all outgoing empty flags. It leaves the interrupt bits and the mailbox data unchanged, and bit 24 always reads 0.
- R10: When a set and a clear hit the same flag in one cycle, the new event wins. A host write beats an add-on read of the same byte. An add-on write beats a host read of the same byte. An interrupt set beats a write-one clear of the same bit.
- R11: While an enable bit is 0, the events of its direction do not set its interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Add-on register address |
| regWr | input | 1 | Add-on register write strobe |
| regRd | input | 1 | Add-on register read strobe |
| regBe | input | 4 | Add-on byte enables |
| regWdata | input | 32 | Add-on write data |
| regRdata | output | 32 | Add-on read data (combinational) |
| hostWrEn | input | 1 | Host write to incoming mailbox |
| hostWrBox | input | 2 | Host write mailbox index |
| hostWrBe | input | 4 | Host write byte enables |
| hostWrData | input | 32 | Host write data |
| hostRdEn | input | 1 | Host read of outgoing mailbox |
| hostRdBox | input | 2 | Host read mailbox index |
| hostRdBe | input | 4 | Host read byte enables |
| hostRdData | output | 32 | Host read data (combinational) |
| irqN | output | 1 | Active-low interrupt to the add-on side |

## Verification
The assertions assume the register strobes address a single register per cycle and that `regRd` and `regWr` are never raised together. Nothing bars the host and add-on ports from touching the same byte in one cycle; the set-wins properties are written for exactly that case. The stimulus drives one register access per cycle, changes inputs only at the falling edge, and raises the host and add-on strobes together only in the conflict scenarios, where those collisions are deliberate.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MB_COUNT   = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned MB_BYTES   = DATA_W / 8;
  localparam int unsigned MB_FLAGS   = MB_COUNT * MB_BYTES;
  localparam int unsigned BOX_IDX_W  = $clog2(MB_COUNT);
  localparam int unsigned ADDR_W     = $clog2(2 * MB_COUNT + 2);

  localparam logic [ADDR_W-1:0] OUT_BASE    = ADDR_W'(MB_COUNT);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(2 * MB_COUNT);
  localparam logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(2 * MB_COUNT + 1);

  localparam int unsigned CTL_IN_EN    = 0;
  localparam int unsigned CTL_OUT_EN   = 1;
  localparam int unsigned CTL_IN_INT   = 16;
  localparam int unsigned CTL_OUT_INT  = 17;
  localparam int unsigned CTL_FLAG_RST = 24;

  typedef struct packed {
    logic [MB_FLAGS-1:0] inLoad;
    logic [MB_FLAGS-1:0] outLoad;
  } mbStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [MB_BYTES-1:0]  regBe,
  input  logic                 wInEn,
  input  logic                 wOutEn,
  input  logic                 wInInt,
  input  logic                 wOutInt,
  input  logic                 wFlagRst,
  input  logic                 hostWrEn,
  input  logic [BOX_IDX_W-1:0] hostWrBox,
  input  logic [MB_BYTES-1:0]  hostWrBe,
  input  logic                 hostRdEn,
  input  logic [BOX_IDX_W-1:0] hostRdBox,
  input  logic [MB_BYTES-1:0]  hostRdBe,
  output mbStrobe_t            strobe,
  output logic [MB_FLAGS-1:0]  inFull,
  output logic [MB_FLAGS-1:0]  outEmpty,
  output logic [DATA_W-1:0]    ctrlWord,
  output logic                 irqN
);
  logic regInRd, regOutWr, ctrlWr, flagRst;
  logic [BOX_IDX_W-1:0] boxSel;
  logic [MB_FLAGS-1:0] hostSetMask, rdClrMask, outClrMask, hostEmptyMask;
  logic inEn, outEn, inInt, outInt;
  logic inSet, outSet, inClrReq, outClrReq, inClr;

  assign boxSel   = regAddr[BOX_IDX_W-1:0];
  assign regInRd  = regRd && (regAddr < OUT_BASE);
  assign regOutWr = regWr && (regAddr >= OUT_BASE) && (regAddr < STATUS_ADDR);
  assign ctrlWr   = regWr && (regAddr == CTRL_ADDR);
  assign flagRst  = ctrlWr && wFlagRst;

  for (genvar b = 0; b < MB_COUNT; b++) begin : g_box
    for (genvar k = 0; k < MB_BYTES; k++) begin : g_byte
      localparam int unsigned IDX = b * MB_BYTES + k;
      assign hostSetMask[IDX]   = hostWrEn && (hostWrBox == BOX_IDX_W'(b)) && hostWrBe[k];
      assign rdClrMask[IDX]     = regInRd && (boxSel == BOX_IDX_W'(b)) && regBe[k];
      assign outClrMask[IDX]    = regOutWr && (boxSel == BOX_IDX_W'(b)) && regBe[k];
      assign hostEmptyMask[IDX] = hostRdEn && (hostRdBox == BOX_IDX_W'(b)) && hostRdBe[k];
    end
  end

  assign inSet     = inEn && (|hostSetMask);
  assign outSet    = outEn && (|hostEmptyMask);
  assign inClrReq  = ctrlWr && wInInt;
  assign outClrReq = ctrlWr && wOutInt;
  assign inClr     = inClrReq && (inFull == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFull   <= '0;
      outEmpty <= '1;
      inEn     <= 1'b0;
      outEn    <= 1'b0;
      inInt    <= 1'b0;
      outInt   <= 1'b0;
    end else begin
      inFull   <= (inFull & ~rdClrMask & ~{MB_FLAGS{flagRst}}) | hostSetMask;
      outEmpty <= (outEmpty | hostEmptyMask | {MB_FLAGS{flagRst}}) & ~outClrMask;
      if (ctrlWr) begin
        inEn  <= wInEn;
        outEn <= wOutEn;
      end
      inInt  <= inSet | (inInt & ~inClr);
      outInt <= outSet | (outInt & ~outClrReq);
    end
  end

  always_comb begin
    ctrlWord              = '0;
    ctrlWord[CTL_IN_EN]   = inEn;
    ctrlWord[CTL_OUT_EN]  = outEn;
    ctrlWord[CTL_IN_INT]  = inInt;
    ctrlWord[CTL_OUT_INT] = outInt;
  end

  assign irqN           = ~(inInt | outInt);
  assign strobe.inLoad  = hostSetMask;
  assign strobe.outLoad = outClrMask;

  assert_full_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|hostSetMask) |=> ((inFull & $past(hostSetMask)) == $past(hostSetMask)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|rdClrMask) && ((rdClrMask & hostSetMask) == '0)) |=> ((inFull & $past(rdClrMask)) == '0));

  assert_out_not_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|outClrMask) |=> ((outEmpty & $past(outClrMask)) == '0));

  assert_sticky_int_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inInt && !inClrReq) |=> inInt);

  assert_irq_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((inInt && !inClrReq) || (outInt && !outClrReq)) |=> !irqN);

  assert_rearm_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inInt && (|inFull)) |=> inInt);

  assert_flag_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagRst && !(|hostSetMask)) |=> ((inFull == '0) && (&outEmpty)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    inSet |=> inInt);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!inInt && !inEn) |=> !inInt);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mbStrobe_t            strobe,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BOX_IDX_W-1:0] hostRdBox,
  input  logic [MB_FLAGS-1:0]  inFull,
  input  logic [MB_FLAGS-1:0]  outEmpty,
  input  logic [DATA_W-1:0]    ctrlWord,
  output logic [DATA_W-1:0]    regRdata,
  output logic [DATA_W-1:0]    hostRdData
);
  logic [7:0] inByte  [MB_FLAGS];
  logic [7:0] outByte [MB_FLAGS];
  logic [DATA_W-1:0] inWord  [MB_COUNT];
  logic [DATA_W-1:0] outWord [MB_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MB_FLAGS; i++) begin
        inByte[i]  <= '0;
        outByte[i] <= '0;
      end
    end else begin
      for (int i = 0; i < MB_FLAGS; i++) begin
        if (strobe.inLoad[i])  inByte[i]  <= hostWrData[(i % MB_BYTES) * 8 +: 8];
        if (strobe.outLoad[i]) outByte[i] <= regWdata[(i % MB_BYTES) * 8 +: 8];
      end
    end
  end

  for (genvar b = 0; b < MB_COUNT; b++) begin : g_word
    for (genvar k = 0; k < MB_BYTES; k++) begin : g_lane
      assign inWord[b][k*8 +: 8]  = inByte[b*MB_BYTES + k];
      assign outWord[b][k*8 +: 8] = outByte[b*MB_BYTES + k];
    end
  end

  always_comb begin
    if (regAddr < OUT_BASE)            regRdata = inWord[regAddr[BOX_IDX_W-1:0]];
    else if (regAddr < STATUS_ADDR)    regRdata = outWord[regAddr[BOX_IDX_W-1:0]];
    else if (regAddr == STATUS_ADDR)   regRdata = {outEmpty, inFull};
    else if (regAddr == CTRL_ADDR)     regRdata = ctrlWord;
    else                               regRdata = '0;
  end

  assign hostRdData = outWord[hostRdBox];
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [MB_BYTES-1:0]  regBe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  logic                 hostWrEn,
  input  logic [BOX_IDX_W-1:0] hostWrBox,
  input  logic [MB_BYTES-1:0]  hostWrBe,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic                 hostRdEn,
  input  logic [BOX_IDX_W-1:0] hostRdBox,
  input  logic [MB_BYTES-1:0]  hostRdBe,
  output logic [DATA_W-1:0]    hostRdData,
  output logic                 irqN
);
  mbStrobe_t            strobe;
  logic [MB_FLAGS-1:0]  inFull, outEmpty;
  logic [DATA_W-1:0]    ctrlWord;

  mbox_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regBe     (regBe),
    .wInEn     (regWdata[CTL_IN_EN]),
    .wOutEn    (regWdata[CTL_OUT_EN]),
    .wInInt    (regWdata[CTL_IN_INT]),
    .wOutInt   (regWdata[CTL_OUT_INT]),
    .wFlagRst  (regWdata[CTL_FLAG_RST]),
    .hostWrEn  (hostWrEn),
    .hostWrBox (hostWrBox),
    .hostWrBe  (hostWrBe),
    .hostRdEn  (hostRdEn),
    .hostRdBox (hostRdBox),
    .hostRdBe  (hostRdBe),
    .strobe    (strobe),
    .inFull    (inFull),
    .outEmpty  (outEmpty),
    .ctrlWord  (ctrlWord),
    .irqN      (irqN)
  );

  mbox_datapath i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .regWdata   (regWdata),
    .regAddr    (regAddr),
    .hostRdBox  (hostRdBox),
    .inFull     (inFull),
    .outEmpty   (outEmpty),
    .ctrlWord   (ctrlWord),
    .regRdata   (regRdata),
    .hostRdData (hostRdData)
  );
endmodule

// File: tb/test_mbox_irq_ctrl.sv
module test_mbox_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [3:0]  regBe = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostWrBox = '0;
  logic [3:0]  hostWrBe = '0;
  logic [31:0] hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [1:0]  hostRdBox = '0;
  logic [3:0]  hostRdBe = '0;
  logic [31:0] hostRdData;
  logic        irqN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  localparam logic [3:0] ST = 4'd8;
  localparam logic [3:0] CT = 4'd9;

  always #10 clk = ~clk;

  mbox_irq_ctrl i_mbox_irq_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata),
    .hostWrEn(hostWrEn), .hostWrBox(hostWrBox), .hostWrBe(hostWrBe),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdBox(hostRdBox),
    .hostRdBe(hostRdBe), .hostRdData(hostRdData), .irqN(irqN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regAddr = a; regWdata = d; regBe = be; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regBe = be; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] box, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    hostWrBox = box; hostWrBe = be; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] box, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    hostRdBox = box; hostRdBe = be; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  task automatic peekCheck(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    regRead(a, 4'h0, d);
    check(tag, d, exp);
  endtask

  task automatic testReset();
    peekCheck("R1 status after reset", ST, 32'hFFFF_0000);
    peekCheck("R1 control after reset", CT, 32'h0);
    check("R1 irqN after reset", {31'd0, irqN}, 32'd1);
  endtask

  task automatic testHostWrite();
    hostWrite(2'd1, 4'b0101, 32'hAABB_CCDD);
    peekCheck("R3 partial full flags", ST, 32'hFFFF_0050);
    peekCheck("R11 disabled no interrupt", CT, 32'h0);
    check("R11 irqN stays high", {31'd0, irqN}, 32'd1);
    regWrite(CT, 32'h0000_0001, 4'hF);
    hostWrite(2'd2, 4'hF, 32'h1122_3344);
    peekCheck("R3 full flags box2", ST, 32'hFFFF_0F50);
    peekCheck("R3 incoming interrupt set", CT, 32'h0001_0001);
    check("R7 irqN asserted", {31'd0, irqN}, 32'd0);
  endtask

  task automatic testAddonRead();
    logic [31:0] d;
    regRead(4'd1, 4'b0001, d);
    check("R4 read data box1", d, 32'h00BB_00DD);
    peekCheck("R4 only byte0 flag cleared", ST, 32'hFFFF_0F40);
  endtask

  task automatic testRearm();
    logic [31:0] d;
    regWrite(CT, 32'h0001_0001, 4'hF);
    peekCheck("R8 clear ignored while full", CT, 32'h0001_0001);
    check("R8 irqN still low", {31'd0, irqN}, 32'd0);
    regRead(4'd1, 4'b0100, d);
    regRead(4'd2, 4'hF, d);
    check("R4 read data box2", d, 32'h1122_3344);
    peekCheck("R4 all incoming drained", ST, 32'hFFFF_0000);
    regWrite(CT, 32'h0001_0001, 4'hF);
    peekCheck("R6 write-one clears", CT, 32'h0000_0001);
    check("R7 irqN released", {31'd0, irqN}, 32'd1);
  endtask

  task automatic testStickyAndFlagReset();
    hostWrite(2'd0, 4'b0001, 32'h0000_0055);
    regWrite(CT, 32'h0000_0001, 4'hF);
    peekCheck("R6 write-zero keeps bit", CT, 32'h0001_0001);
    regWrite(CT, 32'h0100_0001, 4'hF);
    peekCheck("R9 flags reset", ST, 32'hFFFF_0000);
    peekCheck("R9 interrupt kept, bit24 reads 0", CT, 32'h0001_0001);
    peekCheck("R9 data kept", 4'd0, 32'h0000_0055);
    regWrite(CT, 32'h0001_0001, 4'hF);
    peekCheck("R6 clear after flag reset", CT, 32'h0000_0001);
  endtask

  task automatic testOutgoing();
    logic [31:0] d;
    regWrite(CT, 32'h0000_0003, 4'hF);
    regWrite(4'd5, 32'hCAFE_F00D, 4'hF);
    peekCheck("R5 empty flags cleared box1", ST, 32'hFF0F_0000);
    peekCheck("R2 outgoing readback", 4'd5, 32'hCAFE_F00D);
    hostRead(2'd1, 4'b0011, d);
    check("R5 host read data", d, 32'hCAFE_F00D);
    peekCheck("R5 partial empty set", ST, 32'hFF3F_0000);
    peekCheck("R5 outgoing interrupt", CT, 32'h0002_0003);
    check("R7 irqN low on outgoing", {31'd0, irqN}, 32'd0);
    regWrite(CT, 32'h0002_0003, 4'hF);
    peekCheck("R6 outgoing cleared", CT, 32'h0000_0003);
    check("R7 irqN high again", {31'd0, irqN}, 32'd1);
  endtask

  task automatic testConflicts();
    logic [31:0] d;
    // host write vs add-on read of same byte
    @(negedge clk);
    hostWrBox = 2'd3; hostWrBe = 4'b0001; hostWrData = 32'h77; hostWrEn = 1'b1;
    regAddr = 4'd3; regBe = 4'b0001; regRd = 1'b1;
    #1 d = regRdata;
    @(posedge clk); #1;
    hostWrEn = 1'b0; regRd = 1'b0;
    check("R10 read returns old data", d, 32'h0);
    peekCheck("R10 host write beats read", ST, 32'hFF3F_1000);
    regWrite(CT, 32'h0100_0003, 4'hF);
    peekCheck("R9 second flag reset", ST, 32'hFFFF_0000);
    // interrupt set vs write-one clear
    @(negedge clk);
    hostWrBox = 2'd0; hostWrBe = 4'b0001; hostWrData = 32'h66; hostWrEn = 1'b1;
    regAddr = CT; regWdata = 32'h0001_0003; regBe = 4'hF; regWr = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0; regWr = 1'b0;
    peekCheck("R10 set beats clear", CT, 32'h0001_0003);
    // add-on write vs host read of same byte
    @(negedge clk);
    hostRdBox = 2'd2; hostRdBe = 4'b0001; hostRdEn = 1'b1;
    regAddr = 4'd6; regWdata = 32'h99; regBe = 4'b0001; regWr = 1'b1;
    #1 d = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 1'b0; regWr = 1'b0;
    check("R10 host read old data", d, 32'h0);
    peekCheck("R10 write beats host read", ST, 32'hFEFF_0001);
    peekCheck("R5 both interrupts pending", CT, 32'h0003_0003);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testHostWrite();
    testAddonRead();
    testRearm();
    testStickyAndFlagReset();
    testOutgoing();
    testConflicts();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule